// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a four-wire serial control link: an active-low select, a serial clock, serial data in and serial data out. Behind it sits a bank of 256 byte-wide configuration registers. A controller addresses one register per frame. Each frame opens with a start bit of 1 and an operation bit, followed by an 8-bit address sent MSB first. A write frame then carries one or more data bytes. After the first byte, each further byte lands at the next address up. A read frame makes the block shift out a start bit of 1 and then the selected register, MSB first.

The serial pins are brought into the system clock domain through two-flop synchronizers. The block finds the serial clock edges by oversampling, so the register bank and all frame logic run on the system clock. The register bank also has a direct port on the system side, where on-chip logic can read it and write it. A serial write is held pending once its last data bit arrives. It reaches the register bank only on the next falling serial clock edge. That edge can be a dedicated trailing clock or the first bit of the next byte or frame.

Top module: `serial_cfg_port`

## Requirements
- R1: Serial input bits are sampled on falling serial clock edges while the select is low. A frame is a start bit of 1, an operation bit (0 = write, 1 = read), an 8-bit address MSB first and, for a write, an 8-bit data byte MSB first.
- R2: A completed write byte reaches its register only on the first falling serial clock edge after its last data bit. Before that edge the register keeps its old value.
- R3: When the select rises before the falling edge that samples the last data bit, that bit is still taken and the write still commits on the following falling edge, even with the select high.
- R4: Each further 8 bits clocked into a write frame are written to the next address up, with no new header. The address wraps from 0xFF to 0x00.
- R5: In a read frame, from the first rising serial clock edge after the address LSB, one bit per rising edge appears on the output: first a start bit of 1, then the addressed register's 8 bits MSB first.
- R6: The output-enable is low out of reset, during the header, and within one system clock of the select being seen high. It is high only while read bits are being shifted out.
- R7: A frame whose first sampled bit is 0 has no effect: no register changes and the output stays disabled until the select goes high and a new frame begins.
- R8: A frame that immediately follows an uncommitted write needs no extra clock in between. The first falling edge of the new frame commits the pending write, so a read of that register in the new frame returns the new value.
- R9: All registers reset to 0x00. The system-side port returns the register at its address in the same cycle and writes it at the clock edge when its write enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_oe | output | 1 | Output enable for sdo (high = driving) |
| host_addr | input | 8 | System-side register address |
| host_wdata | input | 8 | System-side write data |
| host_we | input | 1 | System-side write enable |
| host_rdata | output | 8 | System-side read data at host_addr |

## Verification
Some timing relations hold on every cycle, and the assertions check them there. A register write only ever follows a detected falling serial clock edge. The serial output changes value only after a rising edge. The output-enable only turns on at a rising edge, and the first bit it then presents is a 1. A select seen high always clears the output-enable on the next cycle. Other behaviours only the bench scenarios can show. These are the frame decoding itself, the exact edge at which a write commits, the late select rise, streaming with address wrap, the returned read bits, ignored frames, and a pending write committed by the next frame's first edge.

// File: rtl/scp_pkg.sv
package scp_pkg;

    // Register bank geometry
    parameter int unsigned SCP_AW = 8;
    parameter int unsigned SCP_DW = 8;
    parameter int unsigned SCP_DEPTH = 1 << SCP_AW;

    // Bit counter covers the longer of the address and data fields
    localparam int unsigned SCP_FIELD = (SCP_AW > SCP_DW) ? SCP_AW : SCP_DW;
    localparam int unsigned SCP_CW = $clog2(SCP_FIELD);

    localparam logic START_VAL = 1'b1;
    localparam logic OP_READ = 1'b1;

    typedef enum logic [2:0] {
        FS_START,
        FS_OP,
        FS_ADDR,
        FS_DATA,
        FS_DONE,
        FS_SKIP
    } frame_st_e;

    typedef struct packed {
        logic [SCP_AW-1:0] addr;
        logic [SCP_DW-1:0] data;
    } wr_cmd_t;

    function automatic logic [SCP_AW-1:0] addr_next(input logic [SCP_AW-1:0] a);
        return a + 1'b1;
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_low,
    output logic cs_fall,
    output logic sclk_fall,
    output logic sclk_rise,
    output logic sdi_s
);
    // bit 2: select, bit 1: serial clock, bit 0: data
    localparam logic [2:0] IDLE_PINS = 3'b110;

    logic [2:0] pipe [STAGES];
    logic [2:0] cur;
    logic       cs_prev;
    logic       sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= IDLE_PINS;
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            pipe[0] <= {cs_n, sclk, sdi};
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
            cs_prev   <= cur[2];
            sclk_prev <= cur[1];
        end
    end

    assign cur       = pipe[STAGES-1];
    assign cs_low    = ~cur[2];
    assign cs_fall   = cs_prev & ~cur[2];
    assign sclk_fall = sclk_prev & ~cur[1];
    assign sclk_rise = ~sclk_prev & cur[1];
    assign sdi_s     = cur[0];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    output logic              wr_en,
    output wr_cmd_t           wr_cmd,
    output logic              rd_load,
    output logic [SCP_AW-1:0] rd_addr
);
    localparam logic [SCP_CW-1:0] ADDR_LAST = SCP_CW'(SCP_AW - 1);
    localparam logic [SCP_CW-1:0] DATA_LAST = SCP_CW'(SCP_DW - 1);

    frame_st_e         state;
    logic [SCP_CW-1:0] cnt;
    logic [SCP_AW-1:0] addr;
    logic [SCP_DW-1:0] dsr;
    logic              is_read;
    logic              pend;
    wr_cmd_t           pend_cmd;
    logic              late_ok;
    logic              take;

    // The last data bit may still arrive after the select has gone high
    assign late_ok = (state == FS_DATA) && (cnt == DATA_LAST);
    assign take    = sclk_fall && (cs_low || late_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FS_START;
            cnt      <= '0;
            addr     <= '0;
            dsr      <= '0;
            is_read  <= 1'b0;
            pend     <= 1'b0;
            pend_cmd <= '0;
            wr_en    <= 1'b0;
            wr_cmd   <= '0;
            rd_load  <= 1'b0;
            rd_addr  <= '0;
        end else begin
            wr_en   <= 1'b0;
            rd_load <= 1'b0;

            // Any falling edge retires a completed byte
            if (sclk_fall && pend) begin
                wr_en  <= 1'b1;
                wr_cmd <= pend_cmd;
                pend   <= 1'b0;
            end

            if (cs_fall) begin
                state <= FS_START;
                cnt   <= '0;
            end else if (take) begin
                unique case (state)
                    FS_START: state <= (sdi_s == START_VAL) ? FS_OP : FS_SKIP;
                    FS_OP: begin
                        is_read <= (sdi_s == OP_READ);
                        cnt     <= '0;
                        state   <= FS_ADDR;
                    end
                    FS_ADDR: begin
                        addr <= {addr[SCP_AW-2:0], sdi_s};
                        cnt  <= cnt + 1'b1;
                        if (cnt == ADDR_LAST) begin
                            cnt <= '0;
                            if (is_read) begin
                                rd_load <= 1'b1;
                                rd_addr <= {addr[SCP_AW-2:0], sdi_s};
                                state   <= FS_DONE;
                            end else begin
                                state <= FS_DATA;
                            end
                        end
                    end
                    FS_DATA: begin
                        dsr <= {dsr[SCP_DW-2:0], sdi_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == DATA_LAST) begin
                            cnt           <= '0;
                            pend          <= 1'b1;
                            pend_cmd.addr <= addr;
                            pend_cmd.data <= {dsr[SCP_DW-2:0], sdi_s};
                            addr          <= addr_next(addr);
                        end
                    end
                    default: state <= state;
                endcase
            end else if (!cs_low && !late_ok) begin
                state <= FS_START;
                cnt   <= '0;
            end
        end
    end
endmodule

// File: rtl/scp_shift_out.sv
module scp_shift_out
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_low,
    input  logic              sclk_rise,
    input  logic              rd_load,
    input  logic [SCP_DW-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int unsigned OUT_BITS = SCP_DW + 1;
    localparam int unsigned OCW = $clog2(OUT_BITS + 1);

    logic [OUT_BITS-1:0] osr;
    logic [OCW-1:0]      left;

    always_ff @(posedge clk) begin
        if (rst) begin
            osr    <= '0;
            left   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (!cs_low) begin
            left   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (rd_load) begin
            osr  <= {START_VAL, rd_data};
            left <= OCW'(OUT_BITS);
        end else if (sclk_rise) begin
            if (left != '0) begin
                sdo    <= osr[OUT_BITS-1];
                osr    <= {osr[OUT_BITS-2:0], 1'b0};
                left   <= left - 1'b1;
                sdo_oe <= 1'b1;
            end else begin
                sdo    <= 1'b0;
                sdo_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scp_regs.sv
module scp_regs
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SCP_AW-1:0] host_addr,
    input  logic [SCP_DW-1:0] host_wdata,
    input  logic              host_we,
    output logic [SCP_DW-1:0] host_rdata,
    input  logic              ser_we,
    input  wr_cmd_t           ser_cmd,
    input  logic [SCP_AW-1:0] ser_raddr,
    output logic [SCP_DW-1:0] ser_rdata
);
    logic [SCP_DW-1:0] mem [SCP_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(SCP_DEPTH); i++) mem[i] <= '0;
        end else begin
            if (host_we) mem[host_addr] <= host_wdata;
            // Serial commit is applied last and so wins a same-address clash
            if (ser_we) mem[ser_cmd.addr] <= ser_cmd.data;
        end
    end

    assign host_rdata = mem[host_addr];
    assign ser_rdata  = mem[ser_raddr];
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [SCP_AW-1:0] host_addr,
    input  logic [SCP_DW-1:0] host_wdata,
    input  logic              host_we,
    output logic [SCP_DW-1:0] host_rdata
);
    logic              cs_low;
    logic              cs_fall;
    logic              sclk_fall;
    logic              sclk_rise;
    logic              sdi_s;
    logic              wr_en;
    wr_cmd_t           wr_cmd;
    logic              rd_load;
    logic [SCP_AW-1:0] rd_addr;
    logic [SCP_DW-1:0] rd_data;

    scp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_low(cs_low), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
        .sclk_rise(sclk_rise), .sdi_s(sdi_s)
    );

    scp_frame u_frame (
        .clk(clk), .rst(rst), .cs_low(cs_low), .cs_fall(cs_fall),
        .sclk_fall(sclk_fall), .sdi_s(sdi_s), .wr_en(wr_en),
        .wr_cmd(wr_cmd), .rd_load(rd_load), .rd_addr(rd_addr)
    );

    scp_regs u_regs (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .ser_we(wr_en),
        .ser_cmd(wr_cmd), .ser_raddr(rd_addr), .ser_rdata(rd_data)
    );

    scp_shift_out u_out (
        .clk(clk), .rst(rst), .cs_low(cs_low), .sclk_rise(sclk_rise),
        .rd_load(rd_load), .rd_data(rd_data), .sdo(sdo), .sdo_oe(sdo_oe)
    );
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk (
    input logic clk,
    input logic rst,
    input logic cs_low,
    input logic sclk_fall,
    input logic sclk_rise,
    input logic wr_en,
    input logic sdo,
    input logic sdo_oe
);
    // R2
    commit_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(sclk_fall));

    // R5
    sdo_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_rise)) |-> $stable(sdo));

    // R5
    first_out_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> (sdo == 1'b1));

    // R6
    oe_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(sclk_rise));

    // R6
    oe_off_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_low |=> !sdo_oe);
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
    .clk(clk), .rst(rst), .cs_low(cs_low), .sclk_fall(sclk_fall),
    .sclk_rise(sclk_rise), .wr_en(wr_en), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/tb_serial_cfg_port.sv
`timescale 1ns/1ps
module tb_serial_cfg_port;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serial_cfg_port dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial clock: data set while high, falling edge, back high
    task automatic sbit(input logic b, output logic got, output logic oe_got);
        sdi = b;
        wait_cyc(HALF);
        got = sdo;
        oe_got = sdo_oe;
        sclk = 1'b0;
        wait_cyc(HALF);
        sclk = 1'b1;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, output logic oe_seen);
        logic g, o;
        oe_seen = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            sbit(v[i], g, o);
            oe_seen |= o;
        end
    endtask

    task automatic select_on();
        cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic select_off();
        cs_n = 1'b1;
        wait_cyc(2 * HALF);
    endtask

    task automatic host_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        host_addr = a;
        wait_cyc(1);
        chk(req, {8'h00, host_rdata}, {8'h00, exp});
    endtask

    task automatic t_reset();
        chk("R6 oe after reset", {15'd0, sdo_oe}, 16'd0);
        host_chk("R9 reset value", 8'h10, 8'h00);
    endtask

    task automatic t_host();
        host_addr = 8'h20; host_wdata = 8'h5A; host_we = 1'b1;
        wait_cyc(1);
        host_we = 1'b0;
        host_chk("R9 host write", 8'h20, 8'h5A);
    endtask

    task automatic t_write_commit();
        logic oe, g, o;
        select_on();
        send_bits({14'd0, 1'b1, 1'b0, 8'h33, 8'hC6}, 18, oe);
        wait_cyc(HALF);
        host_chk("R2 no commit before extra edge", 8'h33, 8'h00);
        sbit(1'b0, g, o);
        wait_cyc(4);
        host_chk("R1 R2 commit on extra edge", 8'h33, 8'hC6);
        select_off();
    endtask

    task automatic t_late_cs();
        logic oe, g, o;
        select_on();
        send_bits({15'd0, 1'b1, 1'b0, 8'h44, 7'b1000000}, 17, oe);
        cs_n = 1'b1;
        sbit(1'b1, g, o);
        sbit(1'b0, g, o);
        wait_cyc(4);
        host_chk("R3 late select rise", 8'h44, 8'h81);
        select_off();
    endtask

    task automatic t_stream();
        logic oe, g, o;
        select_on();
        send_bits({14'd0, 1'b1, 1'b0, 8'hFE, 8'h11}, 18, oe);
        send_bits({8'd0, 8'h22, 8'h33}, 16, oe);
        sbit(1'b0, g, o);
        select_off();
        host_chk("R4 stream first", 8'hFE, 8'h11);
        host_chk("R4 stream next", 8'hFF, 8'h22);
        host_chk("R4 stream wrap", 8'h00, 8'h33);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [8:0] bits,
                           output logic hdr_oe, output logic oe_all);
        logic g, o;
        send_bits({22'd0, 1'b1, 1'b1, a}, 10, hdr_oe);
        oe_all = 1'b1;
        for (int i = 8; i >= 0; i--) begin
            sbit(1'b0, g, o);
            bits[i] = g;
            oe_all &= o;
        end
    endtask

    task automatic t_read();
        logic [8:0] bits;
        logic hdr_oe, oe_all, g, o;
        select_on();
        do_read(8'h33, bits, hdr_oe, oe_all);
        chk("R6 oe low in header", {15'd0, hdr_oe}, 16'd0);
        chk("R5 start bit and data", {7'd0, bits}, {7'd0, 1'b1, 8'hC6});
        chk("R5 oe while shifting", {15'd0, oe_all}, 16'd1);
        sbit(1'b0, g, o);
        cs_n = 1'b1;
        wait_cyc(4);
        chk("R6 oe after deselect", {15'd0, sdo_oe}, 16'd0);
        wait_cyc(2 * HALF);
    endtask

    task automatic t_ignore();
        logic oe, g, o;
        select_on();
        send_bits({13'd0, 1'b0, 1'b1, 1'b0, 8'h50, 8'hFF}, 19, oe);
        sbit(1'b0, g, o);
        chk("R7 oe stays low", {15'd0, oe | o}, 16'd0);
        select_off();
        host_chk("R7 frame ignored", 8'h50, 8'h00);
    endtask

    task automatic t_back_to_back();
        logic [8:0] bits;
        logic oe, hdr_oe, oe_all, g, o;
        select_on();
        send_bits({14'd0, 1'b1, 1'b0, 8'h60, 8'h12}, 18, oe);
        cs_n = 1'b1;
        wait_cyc(HALF);
        host_chk("R8 pending across frames", 8'h60, 8'h00);
        select_on();
        do_read(8'h60, bits, hdr_oe, oe_all);
        chk("R8 read sees prior write", {7'd0, bits}, {7'd0, 1'b1, 8'h12});
        sbit(1'b0, g, o);
        select_off();
        host_chk("R8 committed", 8'h60, 8'h12);
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        t_reset();
        t_host();
        t_write_commit();
        t_late_cs();
        t_stream();
        t_read();
        t_ignore();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule